// File: doc/BRIEF.md
# Clock Reference Operating Mode Controller

This block is the supervisory state machine of a timing-source PLL. It looks at a validity flag for each candidate reference, a ranked list of reference indices, the PLL's lock indicator and a slow periodic tick. From these it decides which operating mode the PLL is in and which reference it should follow. It does not contain the PLL itself. It leaves free-run only once the reference evaluation has finished. It then chooses the best valid reference and gives the PLL a bounded number of ticks to lock. If the PLL does not lock in that time, the block drops back to free-run and the next try avoids the reference that just failed. Once the PLL has been locked for long enough, the block raises a flag that permits holdover.

When the followed reference disappears, the block has three outcomes. If another reference is valid, it switches to that reference through a lost-phase mode. If nothing is valid and holdover has been earned, it enters holdover. Otherwise it returns to free-run. Both the acquisition window and the minimum locked time are parameters counted in ticks, so simulation can use short values.

Top module: `refmode_ctrl`

## Requirements
- R1: While reset is low the block is in free-run (mode code 3'b001), with `selValid` = 0, `selRef` = 0 and `holdoverOk` = 0.
- R2: In free-run the mode stays 3'b001 unless `evalDone` is high and at least one `refValid` bit is set. When both hold, the next clock enters pre-locked (mode 3'b010) with `selValid` = 1.
- R3: The reference loaded on any selection is the first entry of `prioList` whose reference is valid. Entry k sits at bits [k*IDX_W +: IDX_W], and entry 0 has the highest priority.
- R4: In pre-locked, a high `pllLocked` moves the block to locked (mode 3'b100) on the next clock, keeping the same `selRef`.
- R5: In pre-locked or lost-phase, the ACQ_TICKS-th tick without lock returns the block to free-run with `selValid` = 0 and `holdoverOk` = 0. The next selection skips the reference that timed out whenever another reference is valid.
- R6: If the reference that timed out is the only valid one, it is selected again.
- R7: `holdoverOk` rises on the clock of the HOLD_TICKS-th tick spent in locked mode, and never rises before that.
- R8: In locked mode, if the selected reference becomes invalid while another is valid, the next clock enters lost-phase (mode 3'b011) with `selRef` set to the best remaining valid reference. Lost-phase goes back to locked on the clock after `pllLocked` is high.
- R9: In locked mode, if the selected reference becomes invalid, no reference is valid and `holdoverOk` is 1, the next clock enters holdover (mode 3'b101) with `selValid` = 0 and `holdoverOk` kept at 1.
- R10: In the same situation with `holdoverOk` = 0, the next clock enters free-run with `selValid` = 0.
- R11: In holdover, any valid reference moves the block to pre-locked on the next clock, following the R3 choice and without waiting for `evalDone`.
- R12: In pre-locked, if the selected reference becomes invalid, the next clock returns the block to free-run with `selValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refValid | input | NUM_REFS | One validity flag per reference |
| prioList | input | NUM_REFS*IDX_W | Reference indices ranked by priority, entry 0 at the LSBs |
| evalDone | input | 1 | All references have been evaluated |
| pllLocked | input | 1 | PLL lock indicator |
| tick | input | 1 | One-cycle strobe that times acquisition and lock age |
| modeCode | output | 3 | Current mode: 001 free-run, 010 pre-locked, 100 locked, 011 lost-phase, 101 holdover |
| selRef | output | IDX_W | Index of the selected reference |
| selValid | output | 1 | A reference is currently selected |
| holdoverOk | output | 1 | Enough locked time has built up to permit holdover |

## Verification
The bench drives the acquisition window to its exact limit and checks three things. Pre-locked must survive the tick before the limit and end on the limit tick; an off-by-one counter would leave too early or too late. After a timeout, the skipped reference must be the one that failed. It must still be picked when it is the only valid reference, since a design that excludes it unconditionally would stay in free-run for good. The bench follows `holdoverOk` tick by tick through locked mode. It then removes every reference both with and without that flag set. A design that ignored the flag would enter holdover without stable frequency data, or fall to free-run when holdover was allowed. Switchover must pass through lost-phase onto the next-ranked valid reference, not the old one or a lower-ranked one.

// File: rtl/refmode_pkg.sv
package refmode_pkg;

  typedef enum logic [2:0] {
    MODE_FREE    = 3'b001,
    MODE_PRELOCK = 3'b010,
    MODE_LOST    = 3'b011,
    MODE_LOCKED  = 3'b100,
    MODE_HOLD    = 3'b101
  } mode_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadBest;
    logic clearSel;
    logic acqClr;
    logic acqRun;
    logic ageRun;
    logic ageClr;
    logic markFail;
    logic clrFail;
  } strobe_t;

endpackage

// File: rtl/refmode_datapath.sv
module refmode_datapath
  import refmode_pkg::*;
#(
  parameter int NUM_REFS   = 4,
  parameter int IDX_W      = 2,
  parameter int ACQ_TICKS  = 100,
  parameter int HOLD_TICKS = 300
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REFS-1:0]       refValid,
  input  logic [NUM_REFS*IDX_W-1:0] prioList,
  input  logic                      tick,
  input  strobe_t                   strb,
  output logic                      anyValid,
  output logic                      selOk,
  output logic                      acqAtLimit,
  output logic                      holdOk,
  output logic [IDX_W-1:0]          selRef,
  output logic                      selValid
);

  localparam int ACQ_W  = $clog2(ACQ_TICKS + 1);
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [ACQ_W-1:0]  acqCnt;
  logic [HOLD_W-1:0] ageCnt;
  logic [IDX_W-1:0]  failIdx;
  logic              failActive;
  logic [IDX_W-1:0]  plainBest, maskBest, bestIdx, cand;
  logic              plainFound, maskFound;

  // priority scan, lowest entry wins; second result skips the failed ref
  always_comb begin
    plainFound = 1'b0;
    maskFound  = 1'b0;
    plainBest  = '0;
    maskBest   = '0;
    cand       = '0;
    for (int i = NUM_REFS - 1; i >= 0; i--) begin
      cand = prioList[i*IDX_W +: IDX_W];
      if (int'(cand) < NUM_REFS && refValid[cand]) begin
        plainFound = 1'b1;
        plainBest  = cand;
        if (!(failActive && cand == failIdx)) begin
          maskFound = 1'b1;
          maskBest  = cand;
        end
      end
    end
  end

  assign bestIdx    = maskFound ? maskBest : plainBest;
  assign anyValid   = plainFound;
  assign selOk      = selValid && refValid[selRef];
  assign acqAtLimit = tick && (acqCnt == ACQ_W'(ACQ_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selRef   <= '0;
      selValid <= 1'b0;
    end else if (strb.loadBest) begin
      selRef   <= bestIdx;
      selValid <= 1'b1;
    end else if (strb.clearSel) begin
      selValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  acqCnt <= '0;
    else if (strb.acqClr)       acqCnt <= '0;
    else if (strb.acqRun && tick) acqCnt <= acqCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt <= '0;
      holdOk <= 1'b0;
    end else if (strb.ageClr) begin
      ageCnt <= '0;
      holdOk <= 1'b0;
    end else if (strb.ageRun && tick && !holdOk) begin
      if (ageCnt == HOLD_W'(HOLD_TICKS - 1)) holdOk <= 1'b1;
      else                                   ageCnt <= ageCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failIdx    <= '0;
      failActive <= 1'b0;
    end else if (strb.markFail) begin
      failIdx    <= selRef;
      failActive <= 1'b1;
    end else if (strb.clrFail) begin
      failActive <= 1'b0;
    end
  end

endmodule

// File: rtl/refmode_control.sv
module refmode_control
  import refmode_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    evalDone,
  input  logic    pllLocked,
  input  logic    anyValid,
  input  logic    selOk,
  input  logic    acqAtLimit,
  input  logic    holdOk,
  output strobe_t strb,
  output mode_e   mode
);

  mode_e nextMode;

  always_comb begin
    nextMode = mode;
    strb     = '0;
    unique case (mode)
      MODE_FREE: begin
        if (evalDone && anyValid) begin
          nextMode      = MODE_PRELOCK;
          strb.loadBest = 1'b1;
          strb.acqClr   = 1'b1;
        end
      end
      MODE_PRELOCK, MODE_LOST: begin
        strb.acqRun = 1'b1;
        if (!selOk) begin
          if (mode == MODE_LOST && anyValid) begin
            nextMode      = MODE_LOST;
            strb.loadBest = 1'b1;
            strb.acqClr   = 1'b1;
          end else if (mode == MODE_LOST && holdOk) begin
            nextMode      = MODE_HOLD;
            strb.clearSel = 1'b1;
          end else begin
            nextMode      = MODE_FREE;
            strb.clearSel = 1'b1;
            strb.ageClr   = 1'b1;
          end
        end else if (pllLocked) begin
          nextMode     = MODE_LOCKED;
          strb.clrFail = 1'b1;
        end else if (acqAtLimit) begin
          nextMode      = MODE_FREE;
          strb.markFail = 1'b1;
          strb.clearSel = 1'b1;
          strb.ageClr   = 1'b1;
        end
      end
      MODE_LOCKED: begin
        strb.ageRun = 1'b1;
        if (!selOk) begin
          if (anyValid) begin
            nextMode      = MODE_LOST;
            strb.loadBest = 1'b1;
            strb.acqClr   = 1'b1;
          end else if (holdOk) begin
            nextMode      = MODE_HOLD;
            strb.clearSel = 1'b1;
          end else begin
            nextMode      = MODE_FREE;
            strb.clearSel = 1'b1;
            strb.ageClr   = 1'b1;
          end
        end
      end
      MODE_HOLD: begin
        if (anyValid) begin
          nextMode      = MODE_PRELOCK;
          strb.loadBest = 1'b1;
          strb.acqClr   = 1'b1;
        end
      end
      default: begin
        nextMode      = MODE_FREE;
        strb.clearSel = 1'b1;
        strb.ageClr   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_FREE;
    else       mode <= nextMode;
  end

endmodule

// File: rtl/refmode_ctrl.sv
module refmode_ctrl
  import refmode_pkg::*;
#(
  parameter int NUM_REFS   = 4,
  parameter int IDX_W      = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1,
  parameter int ACQ_TICKS  = 100,
  parameter int HOLD_TICKS = 300
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_REFS-1:0]       refValid,
  input  logic [NUM_REFS*IDX_W-1:0] prioList,
  input  logic                      evalDone,
  input  logic                      pllLocked,
  input  logic                      tick,
  output logic [2:0]                modeCode,
  output logic [IDX_W-1:0]          selRef,
  output logic                      selValid,
  output logic                      holdoverOk
);

  strobe_t strb;
  mode_e   mode;
  logic    anyValid, selOk, acqAtLimit;

  refmode_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .evalDone   (evalDone),
    .pllLocked  (pllLocked),
    .anyValid   (anyValid),
    .selOk      (selOk),
    .acqAtLimit (acqAtLimit),
    .holdOk     (holdoverOk),
    .strb       (strb),
    .mode       (mode)
  );

  refmode_datapath #(
    .NUM_REFS   (NUM_REFS),
    .IDX_W      (IDX_W),
    .ACQ_TICKS  (ACQ_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .refValid   (refValid),
    .prioList   (prioList),
    .tick       (tick),
    .strb       (strb),
    .anyValid   (anyValid),
    .selOk      (selOk),
    .acqAtLimit (acqAtLimit),
    .holdOk     (holdoverOk),
    .selRef     (selRef),
    .selValid   (selValid)
  );

  assign modeCode = mode;

endmodule

// File: rtl/refmode_ctrl_chk.sv
module refmode_ctrl_chk #(
  parameter int NUM_REFS = 4,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_REFS-1:0] refValid,
  input logic                pllLocked,
  input logic [2:0]          modeCode,
  input logic [IDX_W-1:0]    selRef,
  input logic                selValid,
  input logic                holdoverOk
);

  // R1: reset holds free-run with nothing selected
  a_r1_reset_free: assert property (@(posedge clk)
    !rstN |=> (modeCode == 3'b001 && !selValid && !holdoverOk));

  // R3: a freshly loaded reference was valid when it was chosen
  a_r3_loaded_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selValid) |-> ((($past(refValid) >> selRef) & NUM_REFS'(1)) != '0));

  // R4: locked is only entered after the PLL reported lock
  a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'b100 && $past(modeCode) != 3'b100) |-> $past(pllLocked));

  // R7: holdover permission only grows while locked
  a_r7_hold_from_locked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdoverOk) |-> $past(modeCode) == 3'b100);

  // R9: holdover has no selected reference and needs permission
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 3'b101 |-> (!selValid && holdoverOk));

  // R10: free-run never carries a selection or holdover permission
  a_r10_free_state: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 3'b001 |-> (!selValid && !holdoverOk));

  // R8: lost-phase always follows some reference
  a_r8_lost_has_sel: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 3'b011 |-> selValid);

endmodule

bind refmode_ctrl refmode_ctrl_chk #(
  .NUM_REFS (NUM_REFS),
  .IDX_W    (IDX_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .refValid   (refValid),
  .pllLocked  (pllLocked),
  .modeCode   (modeCode),
  .selRef     (selRef),
  .selValid   (selValid),
  .holdoverOk (holdoverOk)
);

// File: tb/refmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module refmode_ctrl_tb_top;

  localparam logic [2:0] FREE = 3'b001, PRE = 3'b010, LOST = 3'b011,
                         LOCK = 3'b100, HOLD = 3'b101;

  typedef struct {
    logic [2:0] mode;
    logic       selV;
    logic [1:0] sel;
    logic       hold;
    logic       chkSel;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] refValid = '0;
  logic [7:0] prioList;
  logic       evalDone = 1'b0, pllLocked = 1'b0, tick = 1'b0;
  logic [2:0] modeCode;
  logic [1:0] selRef;
  logic       selValid, holdoverOk;

  int   checks = 0, fails = 0;
  bit   done = 0;
  exp_t sbq[$];

  // ranking: ref2, ref0, ref3, ref1 (entry 0 in the LSBs)
  assign prioList = {2'd1, 2'd3, 2'd0, 2'd2};

  always #10 clk = ~clk;

  refmode_ctrl #(.NUM_REFS(4), .ACQ_TICKS(5), .HOLD_TICKS(4)) dut_i (
    .clk(clk), .rstN(rstN), .refValid(refValid), .prioList(prioList),
    .evalDone(evalDone), .pllLocked(pllLocked), .tick(tick),
    .modeCode(modeCode), .selRef(selRef), .selValid(selValid),
    .holdoverOk(holdoverOk));

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (modeCode !== e.mode || selValid !== e.selV || holdoverOk !== e.hold ||
          ((e.selV || e.chkSel) && selRef !== e.sel)) begin
        fails++;
        $display("FAIL %s: got mode=%b selV=%b sel=%0d hold=%b, expected mode=%b selV=%b sel=%0d hold=%b",
                 e.tag, modeCode, selValid, selRef, holdoverOk, e.mode, e.selV, e.sel, e.hold);
      end
    end
  end

  // driver: one clock, then queue what must appear after it
  task automatic step(input logic [2:0] m, input logic sv, input logic [1:0] s,
                      input logic h, input string tag);
    @(posedge clk);
    sbq.push_back('{m, sv, s, h, 1'b0, tag});
    @(negedge clk);
    #1;
  endtask

  initial begin
    @(negedge clk);
    @(posedge clk);
    sbq.push_back('{FREE, 1'b0, 2'd0, 1'b0, 1'b1, "R1 reset"});
    @(negedge clk); #1;
    rstN = 1'b1;

    refValid = 4'b1010;
    step(FREE, 0, 0, 0, "R2 waits for evalDone");
    evalDone = 1'b1;
    step(PRE, 1, 3, 0, "R2 R3 first selection");
    pllLocked = 1'b1;
    step(LOCK, 1, 3, 0, "R4 lock");
    tick = 1'b1;
    for (int k = 0; k < 3; k++) step(LOCK, 1, 3, 0, "R7 before limit");
    step(LOCK, 1, 3, 1, "R7 at limit");
    tick = 1'b0;

    pllLocked = 1'b0; refValid = 4'b0010;
    step(LOST, 1, 1, 1, "R8 switchover");
    pllLocked = 1'b1;
    step(LOCK, 1, 1, 1, "R8 relock");
    refValid = 4'b0000;
    step(HOLD, 0, 0, 1, "R9 holdover");
    pllLocked = 1'b0; refValid = 4'b0001;
    step(PRE, 1, 0, 1, "R11 leave holdover");

    tick = 1'b1;
    for (int k = 0; k < 4; k++) step(PRE, 1, 0, 1, "R5 window open");
    step(FREE, 0, 0, 0, "R5 timeout");
    tick = 1'b0;
    step(PRE, 1, 0, 0, "R6 only valid ref retried");
    tick = 1'b1;
    for (int k = 0; k < 4; k++) step(PRE, 1, 0, 0, "R5 window open again");
    step(FREE, 0, 0, 0, "R5 second timeout");
    tick = 1'b0;
    refValid = 4'b1001;
    step(PRE, 1, 3, 0, "R5 failed ref skipped");

    refValid = 4'b0001;
    step(FREE, 0, 0, 0, "R12 selected lost in pre-lock");
    step(PRE, 1, 0, 0, "R6 reselect");
    pllLocked = 1'b1;
    step(LOCK, 1, 0, 0, "R4 lock again");
    pllLocked = 1'b0; refValid = 4'b0000;
    step(FREE, 0, 0, 0, "R10 no holdover permission");
    step(FREE, 0, 0, 0, "R2 nothing valid");
    evalDone = 1'b0; refValid = 4'b1111;
    step(FREE, 0, 0, 0, "R2 evaluation pending");
    evalDone = 1'b1;
    step(PRE, 1, 2, 0, "R3 top entry wins");

    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule